// File: doc/BRIEF.md
# Pad-Encrypted Bus Transceiver Datapath

This block is the data path of one end of a two-ended encrypted link carried over a shared 8-bit bus. For sending, it takes a 5-bit key code and adds an even-parity bit. It masks those six bits with a fresh pad word and places the result on the bus behind an active-low output enable. For receiving, it unmasks the bus value with the pad word at the same position and registers the plaintext. The plaintext is split into a 3-bit field and a 2-bit field for two displays, and a parity error flag is kept with it.

The pad words come from an on-chip read-only table. A wrapping counter addresses the table and moves one step for each advance strobe. Two instances built with the same table parameters and stepped by the same strobes therefore use the same pad word for every transfer. An outside timing unit supplies three strobes, all sampled on `clk`: a transmit window, a capture strobe and a pad-advance strobe. Keypad scanning, display decoding and strobe generation are outside this block.

Top module: `padlink_terminal`

## Requirements
- R1: While `rstN` is low and after it is released, `busOeN` is 1 and `busOut`, `dispHi`, `dispLo` and `parityErr` are 0. The pad address is 0.
- R2: The pad word at address a is (a*PAD_MULT + PAD_SEED) mod 2^PAD_W, which is (a*37 + 0x5A) mod 256 by default. Only its low 6 bits are used for masking.
- R3: After a clock edge with `txWindow` high, `busOeN` is 0 and `busOut` is {2'b00, w ^ pad[5:0]}. Here w[4:0] is `keyCode` and w[5] is the XOR of the five `keyCode` bits (even parity).
- R4: After a clock edge with `txWindow` low, `busOeN` is 1 and `busOut` is all zero.
- R5: `busOut[7:6]` is always 0.
- R6: A clock edge with `stepPad` high increments the pad address by one, modulo 256. With `stepPad` low, the address holds. A transfer or capture in the same cycle as a step uses the address from before the step, and 256 steps return to the same pad word.
- R7: On a clock edge with `captureStb` high, the block forms p = busIn[5:0] ^ pad[5:0]. It then sets `dispHi` = p[4:2] and `dispLo` = p[1:0].
- R8: The same capture edge sets `parityErr` to 1 exactly when p[5] differs from the XOR of p[4:0].
- R9: `busIn[7:6]` has no effect on any output.
- R10: While `captureStb` is low, `dispHi`, `dispLo` and `parityErr` hold their values, whatever `busIn` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| keyCode | input | 5 | Key code to send |
| txWindow | input | 1 | Drive the bus in the next cycle |
| stepPad | input | 1 | Advance the pad address |
| captureStb | input | 1 | Capture and decrypt the bus value |
| busIn | input | 8 | Value seen on the shared bus |
| busOut | output | 8 | Encrypted value offered to the bus |
| busOeN | output | 1 | Bus output enable, active low |
| dispHi | output | 3 | Upper display field of the received code |
| dispLo | output | 2 | Lower display field of the received code |
| parityErr | output | 1 | Parity mismatch in the last capture |

## Verification
The bench builds the block with its default parameters: 5 data bits, an 8-bit bus, an 8-bit pad address, multiplier 37 and seed 0x5A. Because the table has only 256 entries, a run of idle steps can carry the address all the way around. The bench does this and confirms that the pad word at address 0 comes back. With the 8-bit bus there are two unused upper lines, so the bench can drive garbage on them and show that it is ignored on receive and never driven on send.

// File: rtl/padlink_pkg.sv
package padlink_pkg;
  typedef struct packed {
    logic load;     // register an encrypted word for the bus
    logic capture;  // decrypt and register the bus value
  } padlinkStrobe_t;
endpackage

// File: rtl/padlink_ctrl.sv
module padlink_ctrl
  import padlink_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txWindow,
  input  logic              stepPad,
  input  logic              captureStb,
  output padlinkStrobe_t    stb,
  output logic [ADDR_W-1:0] padAddr,
  output logic              busOeN
);
  logic [ADDR_W-1:0] addrQ;
  logic              oeNQ;

  // Pad address: wraps naturally at 2^ADDR_W
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        addrQ <= '0;
    else if (stepPad) addrQ <= addrQ + 1'b1;
  end

  // Output enable follows the transmit window one edge later
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) oeNQ <= 1'b1;
    else       oeNQ <= ~txWindow;
  end

  always_comb begin
    stb.load    = txWindow;
    stb.capture = captureStb;
  end

  assign padAddr = addrQ;
  assign busOeN  = oeNQ;
endmodule

// File: rtl/padlink_datapath.sv
module padlink_datapath
  import padlink_pkg::*;
#(
  parameter int DATA_W   = 5,
  parameter int BUS_W    = 8,
  parameter int ADDR_W   = 8,
  parameter int PAD_W    = 8,
  parameter int PAD_MULT = 37,
  parameter int PAD_SEED = 90,
  parameter int HI_W     = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  padlinkStrobe_t    stb,
  input  logic [ADDR_W-1:0] padAddr,
  input  logic [DATA_W-1:0] keyCode,
  input  logic [BUS_W-1:0]  busIn,
  output logic [BUS_W-1:0]  busOut,
  output logic [HI_W-1:0]   dispHi,
  output logic [DATA_W-HI_W-1:0] dispLo,
  output logic              parityErr
);
  localparam int ENC_W = DATA_W + 1;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int LO_W  = DATA_W - HI_W;

  // Pad table, computed from parameters
  logic [PAD_W-1:0] padRom [DEPTH];
  for (genvar g = 0; g < DEPTH; g++) begin : g_rom
    assign padRom[g] = PAD_W'(g * PAD_MULT + PAD_SEED);
  end

  logic [PAD_W-1:0] padWord;
  logic [ENC_W-1:0] padMask;
  assign padWord = padRom[padAddr];
  assign padMask = padWord[ENC_W-1:0];

  // Transmit side: parity on top, payload below, then mask
  logic [ENC_W-1:0] txPlain, txCipher;
  assign txPlain  = {^keyCode, keyCode};
  assign txCipher = txPlain ^ padMask;

  logic [BUS_W-1:0] busOutQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         busOutQ <= '0;
    else if (stb.load) busOutQ <= BUS_W'(txCipher);
    else               busOutQ <= '0;
  end
  assign busOut = busOutQ;

  // Receive side: unmask only the used lines
  logic [ENC_W-1:0] rxPlain;
  logic             rxBad;
  assign rxPlain = busIn[ENC_W-1:0] ^ padMask;
  assign rxBad   = rxPlain[ENC_W-1] ^ (^rxPlain[DATA_W-1:0]);

  logic [DATA_W-1:0] rxDataQ;
  logic              rxBadQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxDataQ <= '0;
      rxBadQ  <= 1'b0;
    end else if (stb.capture) begin
      rxDataQ <= rxPlain[DATA_W-1:0];
      rxBadQ  <= rxBad;
    end
  end

  assign dispHi    = rxDataQ[DATA_W-1:LO_W];
  assign dispLo    = rxDataQ[LO_W-1:0];
  assign parityErr = rxBadQ;
endmodule

// File: rtl/padlink_terminal.sv
module padlink_terminal
  import padlink_pkg::*;
#(
  parameter int DATA_W   = 5,
  parameter int BUS_W    = 8,
  parameter int ADDR_W   = 8,
  parameter int PAD_W    = 8,
  parameter int PAD_MULT = 37,
  parameter int PAD_SEED = 90,
  parameter int HI_W     = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [DATA_W-1:0]      keyCode,
  input  logic                   txWindow,
  input  logic                   stepPad,
  input  logic                   captureStb,
  input  logic [BUS_W-1:0]       busIn,
  output logic [BUS_W-1:0]       busOut,
  output logic                   busOeN,
  output logic [HI_W-1:0]        dispHi,
  output logic [DATA_W-HI_W-1:0] dispLo,
  output logic                   parityErr
);
  padlinkStrobe_t    stb;
  logic [ADDR_W-1:0] padAddr;

  padlink_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .txWindow(txWindow), .stepPad(stepPad),
    .captureStb(captureStb), .stb(stb), .padAddr(padAddr), .busOeN(busOeN)
  );

  padlink_datapath #(
    .DATA_W(DATA_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W), .PAD_W(PAD_W),
    .PAD_MULT(PAD_MULT), .PAD_SEED(PAD_SEED), .HI_W(HI_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .padAddr(padAddr), .keyCode(keyCode),
    .busIn(busIn), .busOut(busOut), .dispHi(dispHi), .dispLo(dispLo),
    .parityErr(parityErr)
  );
endmodule

// File: rtl/padlink_checker.sv
module padlink_checker #(
  parameter int DATA_W = 5,
  parameter int BUS_W  = 8,
  parameter int ADDR_W = 8,
  parameter int HI_W   = 3
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   txWindow,
  input logic                   stepPad,
  input logic                   captureStb,
  input logic [BUS_W-1:0]       busOut,
  input logic                   busOeN,
  input logic [HI_W-1:0]        dispHi,
  input logic [DATA_W-HI_W-1:0] dispLo,
  input logic                   parityErr,
  input logic [ADDR_W-1:0]      padAddr
);
  localparam int ENC_W = DATA_W + 1;

  p_drive_on_window_r3: assert property (@(posedge clk) disable iff (!rstN)
    txWindow |=> !busOeN);

  p_release_off_window_r4: assert property (@(posedge clk) disable iff (!rstN)
    !txWindow |=> (busOeN && busOut == '0));

  p_upper_lines_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    busOut[BUS_W-1:ENC_W] == '0);

  p_addr_steps_r6: assert property (@(posedge clk) disable iff (!rstN)
    stepPad |=> padAddr == ADDR_W'($past(padAddr) + 1'b1));

  p_addr_holds_r6: assert property (@(posedge clk) disable iff (!rstN)
    !stepPad |=> $stable(padAddr));

  p_display_holds_r10: assert property (@(posedge clk) disable iff (!rstN)
    !captureStb |=> ($stable(dispHi) && $stable(dispLo) && $stable(parityErr)));
endmodule

bind padlink_terminal padlink_checker #(
  .DATA_W(DATA_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W), .HI_W(HI_W)
) chk_i (
  .clk(clk), .rstN(rstN), .txWindow(txWindow), .stepPad(stepPad),
  .captureStb(captureStb), .busOut(busOut), .busOeN(busOeN), .dispHi(dispHi),
  .dispLo(dispLo), .parityErr(parityErr), .padAddr(padAddr)
);

// File: tb/padlink_terminal_tb_top.sv
module padlink_terminal_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] keyCode = '0;
  logic       txWindow = 1'b0, stepPad = 1'b0, captureStb = 1'b0;
  logic [7:0] busIn = '0;
  logic [7:0] busOut;
  logic       busOeN;
  logic [2:0] dispHi;
  logic [1:0] dispLo;
  logic       parityErr;

  int nChecks = 0, nFails = 0;
  bit done = 0;
  int addr = 0;

  always #5 clk = ~clk;

  padlink_terminal dut_i (
    .clk(clk), .rstN(rstN), .keyCode(keyCode), .txWindow(txWindow),
    .stepPad(stepPad), .captureStb(captureStb), .busIn(busIn),
    .busOut(busOut), .busOeN(busOeN), .dispHi(dispHi), .dispLo(dispLo),
    .parityErr(parityErr)
  );

  // Vector: {keyCode[4:0], received bus byte[7:0]}
  localparam logic [12:0] VEC [12] = '{
    {5'h00, 8'h00}, {5'h1F, 8'hC5}, {5'h15, 8'h3A}, {5'h0A, 8'hFF},
    {5'h01, 8'h40}, {5'h10, 8'h81}, {5'h07, 8'h2C}, {5'h18, 8'h13},
    {5'h0F, 8'hE7}, {5'h12, 8'h6B}, {5'h03, 8'h98}, {5'h1C, 8'h55}
  };

  function automatic logic [7:0] padOf(int a);
    return 8'((a % 256) * 37 + 8'h5A);   // R2
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [5:0] txW, rxP;
    logic [7:0] held;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 oe", {7'b0, busOeN}, 8'h01);
    check("R1 busOut", busOut, 8'h00);
    check("R1 disp", {3'b0, parityErr, dispHi, dispLo}, 8'h00);
    rstN = 1'b1;
    tick();
    check("R1 after release", {busOeN, 1'b0, parityErr, dispHi, dispLo}, 8'h80);

    // Vector walk: transfer + capture + step in one cycle, then one idle cycle
    foreach (VEC[i]) begin
      keyCode = VEC[i][12:8];
      busIn = VEC[i][7:0];
      txWindow = 1'b1; captureStb = 1'b1; stepPad = 1'b1;
      tick();
      txW = {^VEC[i][12:8], VEC[i][12:8]} ^ padOf(addr)[5:0];
      rxP = VEC[i][5:0] ^ padOf(addr)[5:0];
      check("R3 R5 R6 busOut", busOut, {2'b00, txW});
      check("R3 oe", {7'b0, busOeN}, 8'h00);
      check("R7 R9 disp", {3'b0, dispHi, dispLo}, {3'b0, rxP[4:0]});
      check("R8 parity", {7'b0, parityErr}, {7'b0, rxP[5] ^ (^rxP[4:0])});
      addr++;
      // idle: window off, no capture, bus changes
      held = {3'b0, dispHi, dispLo};
      txWindow = 1'b0; captureStb = 1'b0; stepPad = 1'b0;
      busIn = ~busIn;
      tick();
      check("R4 released", {busOeN, busOut[6:0]}, {1'b1, 7'b0});
      check("R4 R5 upper", busOut, 8'h00);
      check("R10 hold", {3'b0, dispHi, dispLo}, held);
    end

    // R9: only upper lines differ, result must match
    busIn = 8'h00; captureStb = 1'b1;
    tick();
    held = {parityErr, 2'b0, dispHi, dispLo};
    busIn = 8'hC0;
    tick();
    check("R9 upper ignored", {parityErr, 2'b0, dispHi, dispLo}, held);
    captureStb = 1'b0;

    // R6: step around the whole table, pad word at address 0 returns
    stepPad = 1'b1;
    repeat (256 - addr) tick();
    stepPad = 1'b0;
    addr = 0;
    keyCode = 5'h00; txWindow = 1'b1;
    tick();
    check("R6 wrap", busOut, {2'b00, padOf(0)[5:0]});
    // R6: no step -> same pad word again
    tick();
    check("R6 hold", busOut, {2'b00, padOf(0)[5:0]});
    txWindow = 1'b0;
    tick();

    // R1: reset mid-run clears state and address
    keyCode = 5'h01; txWindow = 1'b1; stepPad = 1'b1;
    repeat (5) tick();
    rstN = 1'b0;
    #1;
    check("R1 async", {busOeN, busOut[6:0]}, 8'h80);
    stepPad = 1'b0;
    tick();
    rstN = 1'b1;
    tick();
    check("R1 addr zero", busOut, {2'b00, 6'b100001 ^ padOf(0)[5:0]});

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule